// File: doc/BRIEF.md
# Table-Driven Video Sync Raster Generator

This block builds the sync raster for a video output path out of four small programmable tables instead of fixed porch and pulse counters. A frame is a list of line runs. Each run names a line type and how many consecutive lines use it. A line type is an ordered list of pointers to segment patterns. Each segment pattern is a short list of (duration, value selector) pairs. A selector picks a level from a value table. Each value-table entry also carries the states of a horizontal/composite sync output and a vertical sync output.

The engine runs on the pixel clock and walks these tables. While a pair is active, the stored level replaces either all three 8-bit channels of the incoming pixel or only the green/luma channel. The sync outputs follow the active value entry. Software loads the tables through a simple address/data/write-enable port and then sets an enable bit. Clearing the bit stops the engine and rewinds it to the start of the raster. The programmed durations of each line must add up to the pixels per line, and the repeat counts must add up to the lines per frame.

Top module: `sync_raster_gen`

## Requirements
- R1: After reset and while the engine is disabled, `pix_out` equals `pix_in` from one clock earlier and both sync outputs are low. During reset all outputs are zero.
- R2: Sequence entry i is written at `cfg_addr` = 0x00+i (i = 0..15). `cfg_wdata[9:0]` holds the repeat count and `cfg_wdata[13:10]` holds the line-type index. The entry plays its line type for that many consecutive lines. Two adjacent entries with the same type play back as one unbroken run.
- R3: When the entry whose index equals the programmed last index finishes, playback continues at entry 0, and the raster repeats without end.
- R4: Line type n (n = 1..15) is written at `cfg_addr` = 0x40+n. Pointer slot s is at `cfg_wdata[3s+2:3s]`, for s = 0..7. Slots play in ascending order. A zero pointer ends the line, and any later slots are not played.
- R5: Pair p (p = 0..3) of pattern e (e = 1..7) is written at `cfg_addr` = 0x80+4e+p. `cfg_wdata[11:0]` is the duration in clocks and `cfg_wdata[15:12]` is the selector. Pairs play in order, each for its duration. A pair with duration 0 takes no clocks.
- R6: Selector bits [2:0] pick a value entry. If selector bit 3 is 1, only the green channel `pix[15:8]` takes the level, and red `[23:16]` and blue `[7:0]` pass through. If bit 3 is 0, all three channels take the level.
- R7: Value entry v (v = 0..7) is written at `cfg_addr` = 0xC0+v. `cfg_wdata[7:0]` is the level, bit 8 is the horizontal/composite sync state and bit 9 is the vertical sync state. Both sync states are driven while that value is active.
- R8: The control word at `cfg_addr` = 0x10 holds enable in bit 0 and the last sequence index in bits [7:4]. Clearing enable returns the outputs to pass-through. Setting it again restarts the raster at entry 0, its first line, and the first played pair.
- R9: Output pixel and sync signals are registered, with exactly one clock from `pix_in` to `pix_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table/control write strobe |
| cfg_addr | input | 8 | Write address: bits [7:6] select the table, bits [5:0] select the entry |
| cfg_wdata | input | 24 | Write data |
| pix_in | input | 24 | Input pixel {R, G, B} |
| pix_out | output | 24 | Output pixel after level substitution |
| hsync_out | output | 1 | Horizontal/composite sync |
| vsync_out | output | 1 | Vertical sync |

## Verification
A wrong segment position or duration count shows at `pix_out` in the very next clock as a wrong level or wrong channel mask. The whole rest of the raster then stays shifted, so a comparison over two full frames exposes any off-by-one in duration, pair, slot or line counting. A wrong sequence index or wrap shows up as a wrong line type in the frame where the last entry ends, and it is seen again at the second frame start. Errors in the enable handling show at the first clock after the control write, as a missing pass-through or as a restart that does not begin with the first pair.

// File: rtl/sync_raster_pkg.sv
package sync_raster_pkg;
    localparam int SEQ_N   = 16;
    localparam int TYPE_N  = 16;
    localparam int SLOT_N  = 8;
    localparam int PAT_N   = 8;
    localparam int PAIR_N  = 4;
    localparam int VAL_N   = 8;
    localparam int CNT_W   = 10;
    localparam int DUR_W   = 12;
    localparam int LVL_W   = 8;
    localparam int CH_N    = 3;
    localparam int G_CH    = 1;
    localparam int ADDR_W  = 8;

    localparam int SEQ_W   = $clog2(SEQ_N);
    localparam int TYPE_W  = $clog2(TYPE_N);
    localparam int PTR_W   = $clog2(PAT_N);
    localparam int VAL_W   = $clog2(VAL_N);
    localparam int SEL_W   = VAL_W + 1;
    localparam int PAIR_W  = $clog2(PAIR_N);
    localparam int POS_W   = $clog2(SLOT_N * PAIR_N);
    localparam int PIX_W   = CH_N * LVL_W;
    localparam int DATA_W  = SLOT_N * PTR_W;
    localparam int IDX_W   = ADDR_W - 2;

    localparam int SEQ_TYPE_LSB  = CNT_W;
    localparam int CTRL_LAST_LSB = 4;
    localparam int CTRL_IDX      = SEQ_N;
    localparam int SEL_LSB       = DUR_W;
    localparam int HS_BIT        = LVL_W;
    localparam int VS_BIT        = LVL_W + 1;

    localparam logic [1:0] TBL_SEQ  = 2'd0;
    localparam logic [1:0] TBL_TYPE = 2'd1;
    localparam logic [1:0] TBL_PAT  = 2'd2;
    localparam logic [1:0] TBL_VAL  = 2'd3;

    typedef logic [SEQ_N-1:0][TYPE_W-1:0]              seq_type_t;
    typedef logic [SEQ_N-1:0][CNT_W-1:0]               seq_cnt_t;
    typedef logic [SLOT_N-1:0][PTR_W-1:0]              slots_t;
    typedef slots_t [TYPE_N-1:0]                       type_tab_t;
    typedef logic [PAT_N-1:0][PAIR_N-1:0][DUR_W-1:0]   pat_dur_t;
    typedef logic [PAT_N-1:0][PAIR_N-1:0][SEL_W-1:0]   pat_sel_t;
    typedef logic [VAL_N-1:0][LVL_W-1:0]               val_lvl_t;

    typedef struct packed {
        seq_type_t          seq_type;
        seq_cnt_t           seq_cnt;
        type_tab_t          type_ptr;
        pat_dur_t           pat_dur;
        pat_sel_t           pat_sel;
        val_lvl_t           val_lvl;
        logic [VAL_N-1:0]   val_hs;
        logic [VAL_N-1:0]   val_vs;
        logic               en;
        logic [SEQ_W-1:0]   last;
    } cfg_t;

    typedef struct packed {
        logic [SEQ_W-1:0]   seq;
        logic [CNT_W-1:0]   line;
        logic [POS_W-1:0]   pos;
        logic               active;
        logic [DUR_W-1:0]   dur;
    } eng_t;

    typedef struct packed {
        logic [PIX_W-1:0]   pix;
        logic               hs;
        logic               vs;
    } out_t;
endpackage

// File: rtl/srg_cfg_regs.sv
module srg_cfg_regs
    import sync_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    logic [1:0]        tbl;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-PAIR_W-1:0] pe;
    logic [PAIR_W-1:0] pp;

    assign tbl = addr[ADDR_W-1 -: 2];
    assign idx = addr[IDX_W-1:0];
    assign pe  = idx[IDX_W-1:PAIR_W];
    assign pp  = idx[PAIR_W-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (tbl)
                TBL_SEQ: begin
                    if (int'(idx) < SEQ_N) begin
                        cfg_d.seq_cnt[idx[SEQ_W-1:0]]  = wdata[CNT_W-1:0];
                        cfg_d.seq_type[idx[SEQ_W-1:0]] = wdata[SEQ_TYPE_LSB +: TYPE_W];
                    end else if (int'(idx) == CTRL_IDX) begin
                        cfg_d.en   = wdata[0];
                        cfg_d.last = wdata[CTRL_LAST_LSB +: SEQ_W];
                    end
                end
                TBL_TYPE: begin
                    if (idx != '0 && int'(idx) < TYPE_N)
                        cfg_d.type_ptr[idx[TYPE_W-1:0]] = wdata;
                end
                TBL_PAT: begin
                    if (pe != '0 && int'(pe) < PAT_N) begin
                        cfg_d.pat_dur[pe[PTR_W-1:0]][pp] = wdata[DUR_W-1:0];
                        cfg_d.pat_sel[pe[PTR_W-1:0]][pp] = wdata[SEL_LSB +: SEL_W];
                    end
                end
                default: begin
                    if (int'(idx) < VAL_N) begin
                        cfg_d.val_lvl[idx[VAL_W-1:0]] = wdata[LVL_W-1:0];
                        cfg_d.val_hs[idx[VAL_W-1:0]]  = wdata[HS_BIT];
                        cfg_d.val_vs[idx[VAL_W-1:0]]  = wdata[VS_BIT];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/srg_pos_finder.sv
module srg_pos_finder
    import sync_raster_pkg::*;
(
    input  slots_t           ptrs,
    input  pat_dur_t         durs,
    input  logic             from_start,
    input  logic [POS_W-1:0] cur_pos,
    output logic             found,
    output logic [POS_W-1:0] pos
);
    logic ended;

    always_comb begin
        found = 1'b0;
        pos   = '0;
        ended = 1'b0;
        for (int s = 0; s < SLOT_N; s++) begin
            if (ptrs[s] == '0) ended = 1'b1;
            for (int p = 0; p < PAIR_N; p++) begin
                if (!ended && !found &&
                    (from_start || (s * PAIR_N + p) > int'(cur_pos)) &&
                    durs[ptrs[s]][p] != '0) begin
                    found = 1'b1;
                    pos   = POS_W'(s * PAIR_N + p);
                end
            end
        end
    end
endmodule

// File: rtl/srg_engine.sv
module srg_engine
    import sync_raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEQ_W-1:0] last,
    input  seq_type_t        seq_type,
    input  seq_cnt_t         seq_cnt,
    input  type_tab_t        type_ptr,
    input  pat_dur_t         pat_dur,
    input  pat_sel_t         pat_sel,
    output eng_t             st,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [DUR_W-1:0] cur_lim,
    output logic [SEL_W-1:0] cur_sel
);
    eng_t st_d, st_q;

    slots_t             cur_slots, nxt_slots;
    logic [SEQ_W-1:0]   seq_adv, seq_n;
    logic [CNT_W:0]     line_inc;
    logic               line_last, pair_done;
    logic               a_found, b_found;
    logic [POS_W-1:0]   a_pos, b_pos;

    assign cur_slots = type_ptr[seq_type[st_q.seq]];
    assign cur_ptr   = cur_slots[st_q.pos[POS_W-1:PAIR_W]];
    assign cur_lim   = pat_dur[cur_ptr][st_q.pos[PAIR_W-1:0]];
    assign cur_sel   = pat_sel[cur_ptr][st_q.pos[PAIR_W-1:0]];

    assign line_inc  = {1'b0, st_q.line} + {{CNT_W{1'b0}}, 1'b1};
    assign line_last = line_inc >= {1'b0, seq_cnt[st_q.seq]};
    assign seq_adv   = !line_last ? st_q.seq :
                       (st_q.seq == last) ? '0 : st_q.seq + SEQ_W'(1);
    assign seq_n     = en ? seq_adv : '0;
    assign nxt_slots = type_ptr[seq_type[seq_n]];
    assign pair_done = !st_q.active || (st_q.dur == cur_lim - DUR_W'(1));

    srg_pos_finder u_find_cur (
        .ptrs       (cur_slots),
        .durs       (pat_dur),
        .from_start (1'b0),
        .cur_pos    (st_q.pos),
        .found      (a_found),
        .pos        (a_pos)
    );

    srg_pos_finder u_find_next (
        .ptrs       (nxt_slots),
        .durs       (pat_dur),
        .from_start (1'b1),
        .cur_pos    ('0),
        .found      (b_found),
        .pos        (b_pos)
    );

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.seq    = '0;
            st_d.line   = '0;
            st_d.pos    = b_pos;
            st_d.active = b_found;
            st_d.dur    = '0;
        end else if (!pair_done) begin
            st_d.dur = st_q.dur + DUR_W'(1);
        end else if (a_found) begin
            st_d.pos = a_pos;
            st_d.dur = '0;
        end else begin
            st_d.seq    = seq_n;
            st_d.line   = line_last ? '0 : line_inc[CNT_W-1:0];
            st_d.pos    = b_pos;
            st_d.active = b_found;
            st_d.dur    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/srg_out_stage.sv
module srg_out_stage
    import sync_raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    input  val_lvl_t         val_lvl,
    input  logic [VAL_N-1:0] val_hs,
    input  logic [VAL_N-1:0] val_vs,
    input  logic [PIX_W-1:0] pix_in,
    output out_t             out
);
    out_t out_d, out_q;
    logic             drive;
    logic [LVL_W-1:0] lvl;
    logic             g_only;
    logic [PIX_W-1:0] pix_sub;

    assign drive  = en && active;
    assign lvl    = val_lvl[sel[VAL_W-1:0]];
    assign g_only = sel[SEL_W-1];

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        logic take;
        assign take = drive && (!g_only || ch == G_CH);
        assign pix_sub[ch*LVL_W +: LVL_W] = take ? lvl : pix_in[ch*LVL_W +: LVL_W];
    end

    always_comb begin
        out_d.pix = pix_sub;
        out_d.hs  = drive && val_hs[sel[VAL_W-1:0]];
        out_d.vs  = drive && val_vs[sel[VAL_W-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out = out_q;
endmodule

// File: rtl/sync_raster_gen.sv
module sync_raster_gen
    import sync_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [PIX_W-1:0]  pix_out,
    output logic              hsync_out,
    output logic              vsync_out
);
    cfg_t             cfg;
    eng_t             eng_st;
    logic [PTR_W-1:0] cur_ptr;
    logic [DUR_W-1:0] cur_lim;
    logic [SEL_W-1:0] cur_sel;
    out_t             out;

    srg_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    srg_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.en),
        .last     (cfg.last),
        .seq_type (cfg.seq_type),
        .seq_cnt  (cfg.seq_cnt),
        .type_ptr (cfg.type_ptr),
        .pat_dur  (cfg.pat_dur),
        .pat_sel  (cfg.pat_sel),
        .st       (eng_st),
        .cur_ptr  (cur_ptr),
        .cur_lim  (cur_lim),
        .cur_sel  (cur_sel)
    );

    srg_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg.en),
        .active  (eng_st.active),
        .sel     (cur_sel),
        .val_lvl (cfg.val_lvl),
        .val_hs  (cfg.val_hs),
        .val_vs  (cfg.val_vs),
        .pix_in  (pix_in),
        .out     (out)
    );

    assign pix_out   = out.pix;
    assign hsync_out = out.hs;
    assign vsync_out = out.vs;
endmodule

// File: rtl/srg_checker.sv
module srg_checker
    import sync_raster_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             active,
    input logic [SEL_W-1:0] sel,
    input logic [SEQ_W-1:0] seq,
    input logic [CNT_W-1:0] line,
    input logic [DUR_W-1:0] dur,
    input logic [PTR_W-1:0] cur_ptr,
    input logic [DUR_W-1:0] cur_lim,
    input logic [PIX_W-1:0] pix_in,
    input logic [PIX_W-1:0] pix_out,
    input logic             hs,
    input logic             vs
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(en) |-> pix_out == $past(pix_in) && !hs && !vs);

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(en) && en && seq != $past(seq) |->
        seq == SEQ_W'($past(seq) + SEQ_W'(1)) || seq == '0);

    p_ptr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && active |-> cur_ptr != '0);

    p_dur_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && active |-> cur_lim != '0 && dur < cur_lim);

    p_keep_rb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(en && active && sel[SEL_W-1]) |->
        pix_out[PIX_W-1 -: LVL_W] == $past(pix_in[PIX_W-1 -: LVL_W]) &&
        pix_out[LVL_W-1:0] == $past(pix_in[LVL_W-1:0]));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(en) |-> seq == '0 && line == '0 && dur == '0);
endmodule

bind sync_raster_gen srg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .active  (eng_st.active),
    .sel     (cur_sel),
    .seq     (eng_st.seq),
    .line    (eng_st.line),
    .dur     (eng_st.dur),
    .cur_ptr (cur_ptr),
    .cur_lim (cur_lim),
    .pix_in  (pix_in),
    .pix_out (pix_out),
    .hs      (hsync_out),
    .vs      (vsync_out)
);

// File: tb/sync_raster_gen_tb.sv
module sync_raster_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int FRAME_LEN  = 17;

    // Expected frame, one row per clock: {green_only, value_index[2:0]}
    localparam logic [3:0] FRAME [FRAME_LEN] = '{
        4'h0, 4'h0, 4'h9, 4'h2,
        4'h0, 4'h0, 4'h9, 4'h2,
        4'h0, 4'h0, 4'h9, 4'h2,
        4'h2, 4'h0, 4'h0, 4'h9, 4'h2
    };
    localparam logic [7:0] LVL [3] = '{8'h10, 8'h80, 8'h20};
    localparam logic       HSV [3] = '{1'b1, 1'b0, 1'b1};
    localparam logic       VSV [3] = '{1'b0, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [23:0] cfg_wdata;
    logic [23:0] pix_in;
    logic [23:0] pix_out;
    logic        hsync_out, vsync_out;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_raster_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pix_in    (pix_in),
        .pix_out   (pix_out),
        .hsync_out (hsync_out),
        .vsync_out (vsync_out)
    );

    function automatic logic [23:0] pix_f(input int k);
        logic [7:0] b = 8'(k);
        return {b, b + 8'h40, b ^ 8'hA5};
    endfunction

    function automatic logic [25:0] expect_out(input logic [23:0] pin, input logic [3:0] code);
        int v = int'(code[2:0]);
        logic [23:0] p;
        p = code[3] ? {pin[23:16], LVL[v], pin[7:0]} : {3{LVL[v]}};
        return {HSV[v], VSV[v], p};
    endfunction

    task automatic check(input string tag, input logic [25:0] got, input logic [25:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got hs/vs/pix=%b/%b/%h expected %b/%b/%h",
                     tag, got[25], got[24], got[23:0], exp[25], exp[24], exp[23:0]);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_cyc(input logic [23:0] pin, input logic [25:0] exp, input string tag);
        pix_in = pin;
        @(negedge clk);
        check(tag, {hsync_out, vsync_out, pix_out}, exp);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pix_in = 24'h5A5A5A;
        repeat (3) @(negedge clk);
        check("R1 reset outputs zero", {hsync_out, vsync_out, pix_out}, 26'h0);
        rst_n = 1'b1;
        run_cyc(24'h123456, {2'b00, 24'h123456}, "R1 R9 disabled pass-through");

        // values: v0 lvl 10 hs, v1 lvl 80, v2 lvl 20 hs vs
        wr(8'hC0, 24'h000110);
        wr(8'hC1, 24'h000080);
        wr(8'hC2, 24'h000320);
        // pattern 1: (2,v0) (0,skip) (1,v1 green only) (0)
        wr(8'h84, 24'h000002);
        wr(8'h85, 24'h002000);
        wr(8'h86, 24'h009001);
        // pattern 2: (1,v2)
        wr(8'h88, 24'h002001);
        // type 1: slots 1,2,0,1 (slot after zero must not play)
        wr(8'h41, 24'h000211);
        // type 2: slots 2,1,2
        wr(8'h42, 24'h00008A);
        // sequence: type1 x2, type1 x1, type2 x1
        wr(8'h00, 24'h000402);
        wr(8'h01, 24'h000401);
        wr(8'h02, 24'h000801);
        run_cyc(24'h0F0F0F, {2'b00, 24'h0F0F0F}, "R1 still disabled after table load");
        wr(8'h10, 24'h000021);

        for (int k = 0; k < 2 * FRAME_LEN; k++) begin
            run_cyc(pix_f(k), expect_out(pix_f(k), FRAME[k % FRAME_LEN]),
                    $sformatf("R2 R3 R4 R5 R6 R7 R9 frame cycle %0d", k));
        end

        wr(8'h10, 24'h000020);
        run_cyc(24'hABCDEF, {2'b00, 24'hABCDEF}, "R8 disable gives pass-through");
        wr(8'h10, 24'h000021);
        for (int k = 0; k < 6; k++) begin
            run_cyc(pix_f(k + 100), expect_out(pix_f(k + 100), FRAME[k]),
                    $sformatf("R8 restart cycle %0d", k));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule